// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner

This block takes a serial stream, one bit per cycle of a bit-rate clock, in which each 10-bit data word is wrapped in a 12-bit frame. The frame opens with a start bit of 1 and closes with a stop bit of 0. Every stop-to-start boundary is a guaranteed 0-to-1 transition. The block does not hunt for a special sync word. It watches every bit slot of a 12-cycle window and drops each slot that shows no rising edge in some window. When exactly one slot is left, that slot is the frame boundary. Lock can therefore be found on live pseudorandom traffic, and a receiver can join a shared link without stalling the other receivers on it.

Once locked, the block removes the two framing bits and presents each data word on a parallel output with a one-cycle strobe. It keeps checking that the boundary edge is still there. If the edge goes missing for a programmable number of consecutive frames, lock is dropped and the search starts again. The lock indicator is active low.

Top module: `frame_aligner`

## Requirements
- R1: Each word is the 10 bits received between a start bit and its stop bit. The first data bit received appears on `word_out[9]` and the last on `word_out[0]`.
- R2: `word_vld` is a one-cycle pulse that carries `word_out`. Exactly one word is issued for every frame whose stop bit is sampled while the block is locked, in the cycle after that stop bit.
- R3: While `srst` is high, and in the first cycle after it is released, `lock_n` is 1, `word_vld` is 0 and `word_out` is 0.
- R4: A stream of sync frames (six ones then six zeros) brings `lock_n` low within 42 frame periods.
- R5: A candidate slot is dropped in any 12-bit window in which it shows no rising edge (a 1 sampled after a 0). Lock is declared at the end of the window that leaves exactly one candidate. Framed pseudorandom data therefore reaches lock, with the boundary at the start bit.
- R6: If the data holds a second rising edge at the same slot in every frame, two candidates survive and `lock_n` stays high.
- R7: Windows are counted from the first bit sampled after `srst` is released: bits 12k to 12k+11 form window k. If a window leaves no candidate, the search restarts with all 12 slots and the current window's edges discarded.
- R8: While locked, a frame with no rising edge at the locked slot counts as a miss, and a frame that has the edge clears the count. When consecutive misses reach `miss_lim`, `lock_n` goes high and a new search begins.
- R9: A `miss_lim` of 0 behaves as 1: a single missed edge drops lock.
- R10: No `word_vld` pulse occurs while the block is unlocked.
- R11: `srst` is synchronous and can be applied at any point in operation. It abandons any lock and clears any partial word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| srst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Serial data, one bit per cycle |
| miss_lim | input | MISS_W (4) | Consecutive missed boundary edges that drop lock; 0 acts as 1 |
| lock_n | output | 1 | Low while locked to a frame boundary |
| word_out | output | DATA_W (10) | Deframed data word, first received bit in the MSB |
| word_vld | output | 1 | One-cycle strobe marking a new word on word_out |

## Verification
The bench drives a frame stream in which a permanent second edge keeps two candidates alive. It then slips the stream by two bits, exactly on a window boundary, so the candidate set empties. A design that never refills its mask would stay unlocked forever, and one that locked on two survivors would put out misaligned words. Missed-edge runs of two frames, separated by a good frame, must not drop lock, while a third consecutive miss must. This exposes a counter that is never cleared or that is off by one, and a limit of zero catches a design that never drops. Every word is checked against a queue filled at the stop-bit instant, so a wrong boundary slot, a reversed bit order or a stray strobe while unlocked shows up as a mismatch.

// File: rtl/fa_pkg.sv
package fa_pkg;

  typedef int unsigned uint_t;

  // Slot of the stop bit that precedes a start bit at slot start_slot.
  function automatic uint_t stop_slot(input uint_t start_slot, input uint_t frame_w);
    return (start_slot == 0) ? frame_w - 1 : start_slot - 1;
  endfunction

  // Index of the set bit in a one-hot vector of width n (highest wins).
  function automatic uint_t set_index(input logic [31:0] v, input uint_t n);
    uint_t idx;
    idx = 0;
    for (int i = 0; i < 32; i++) begin
      if ((uint_t'(i) < n) && v[i]) idx = uint_t'(i);
    end
    return idx;
  endfunction

  // True when one more miss reaches the limit; a zero limit acts as one.
  function automatic logic miss_limit_hit(input uint_t misses_so_far, input uint_t limit);
    uint_t eff;
    eff = (limit == 0) ? 1 : limit;
    return (misses_so_far + 1) >= eff;
  endfunction

endpackage

// File: rtl/fa_phase_ctr.sv
module fa_phase_ctr #(
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned PH_W    = $clog2(FRAME_W)
) (
  input  logic            clk,
  input  logic            srst,
  output logic [PH_W-1:0] phase,
  output logic            frame_end
);

  assign frame_end = (phase == PH_W'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (srst) phase <= '0;
    else      phase <= frame_end ? '0 : phase + 1'b1;
  end

endmodule

// File: rtl/fa_edge_collect.sv
module fa_edge_collect #(
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned PH_W    = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               srst,
  input  logic               ser_bit,
  input  logic [PH_W-1:0]    phase,
  input  logic               frame_end,
  output logic [FRAME_W-1:0] frame_edges
);

  logic               prev_bit;
  logic               rise;
  logic [FRAME_W-1:0] seen;
  logic [FRAME_W-1:0] rise_vec;

  assign rise = ser_bit & ~prev_bit;

  for (genvar g = 0; g < FRAME_W; g++) begin : g_slot
    assign rise_vec[g] = rise & (phase == PH_W'(g));
  end

  // Edges of the window so far, including the current cycle.
  assign frame_edges = seen | rise_vec;

  always_ff @(posedge clk) begin
    if (srst) begin
      prev_bit <= 1'b1;
      seen     <= '0;
    end else begin
      prev_bit <= ser_bit;
      seen     <= frame_end ? '0 : frame_edges;
    end
  end

endmodule

// File: rtl/fa_cand_track.sv
module fa_cand_track #(
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned MISS_W  = 4,
  parameter int unsigned PH_W    = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               srst,
  input  logic               frame_end,
  input  logic [FRAME_W-1:0] frame_edges,
  input  logic [MISS_W-1:0]  miss_lim,
  output logic               locked,
  output logic [FRAME_W-1:0] cand_mask,
  output logic [PH_W-1:0]    lock_pos,
  output logic [MISS_W-1:0]  miss_cnt,
  output logic               lock_evt,
  output logic               restart_evt,
  output logic               drop_evt
);
  import fa_pkg::*;

  localparam logic [FRAME_W-1:0] ALL_CAND = {FRAME_W{1'b1}};

  logic [FRAME_W-1:0] survivors;
  logic               hit;
  logic               single;
  logic               limit_hit;

  assign survivors   = cand_mask & frame_edges;
  assign hit         = |survivors;
  assign single      = ($countones(survivors) == 1);
  assign limit_hit   = miss_limit_hit(uint_t'(miss_cnt), uint_t'(miss_lim));

  assign lock_evt    = frame_end & ~locked & single;
  assign restart_evt = frame_end & ~locked & ~hit;
  assign drop_evt    = frame_end & locked & ~hit & limit_hit;

  assign lock_pos    = PH_W'(set_index(32'(cand_mask), FRAME_W));

  always_ff @(posedge clk) begin
    if (srst) begin
      cand_mask <= ALL_CAND;
      locked    <= 1'b0;
      miss_cnt  <= '0;
    end else if (frame_end) begin
      if (locked) begin
        if (hit) begin
          miss_cnt <= '0;
        end else if (limit_hit) begin
          locked    <= 1'b0;
          cand_mask <= ALL_CAND;
          miss_cnt  <= '0;
        end else begin
          miss_cnt <= miss_cnt + 1'b1;
        end
      end else if (!hit) begin
        cand_mask <= ALL_CAND;
      end else begin
        cand_mask <= survivors;
        if (single) locked <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fa_word_extract.sv
module fa_word_extract #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned PH_W   = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              ser_bit,
  input  logic [PH_W-1:0]   phase,
  input  logic              locked,
  input  logic [PH_W-1:0]   lock_pos,
  output logic [DATA_W-1:0] word_out,
  output logic              word_vld
);
  import fa_pkg::*;

  localparam int unsigned FRAME_W = DATA_W + 2;

  logic [DATA_W:0]   hist;      // start bit plus data bits, oldest at the top
  logic [PH_W-1:0]   stop_ph;
  logic              emit;

  assign stop_ph = PH_W'(stop_slot(uint_t'(lock_pos), FRAME_W));
  assign emit    = locked & (phase == stop_ph);

  always_ff @(posedge clk) begin
    if (srst) begin
      hist     <= '0;
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      hist     <= {hist[DATA_W-1:0], ser_bit};
      word_vld <= emit;
      if (emit) word_out <= hist[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/frame_aligner.sv
module frame_aligner #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned MISS_W = 4
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              ser_bit,
  input  logic [MISS_W-1:0] miss_lim,
  output logic              lock_n,
  output logic [DATA_W-1:0] word_out,
  output logic              word_vld
);

  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned PH_W    = $clog2(FRAME_W);

  logic [PH_W-1:0]    phase;
  logic               frame_end;
  logic [FRAME_W-1:0] frame_edges;
  logic [FRAME_W-1:0] cand_mask;
  logic [PH_W-1:0]    lock_pos;
  logic [MISS_W-1:0]  miss_cnt;
  logic               locked;
  logic               lock_evt;
  logic               restart_evt;
  logic               drop_evt;

  fa_phase_ctr #(.FRAME_W(FRAME_W), .PH_W(PH_W)) i_phase (
    .clk       (clk),
    .srst      (srst),
    .phase     (phase),
    .frame_end (frame_end)
  );

  fa_edge_collect #(.FRAME_W(FRAME_W), .PH_W(PH_W)) i_edges (
    .clk         (clk),
    .srst        (srst),
    .ser_bit     (ser_bit),
    .phase       (phase),
    .frame_end   (frame_end),
    .frame_edges (frame_edges)
  );

  fa_cand_track #(.FRAME_W(FRAME_W), .MISS_W(MISS_W), .PH_W(PH_W)) i_track (
    .clk         (clk),
    .srst        (srst),
    .frame_end   (frame_end),
    .frame_edges (frame_edges),
    .miss_lim    (miss_lim),
    .locked      (locked),
    .cand_mask   (cand_mask),
    .lock_pos    (lock_pos),
    .miss_cnt    (miss_cnt),
    .lock_evt    (lock_evt),
    .restart_evt (restart_evt),
    .drop_evt    (drop_evt)
  );

  fa_word_extract #(.DATA_W(DATA_W), .PH_W(PH_W)) i_extract (
    .clk      (clk),
    .srst     (srst),
    .ser_bit  (ser_bit),
    .phase    (phase),
    .locked   (locked),
    .lock_pos (lock_pos),
    .word_out (word_out),
    .word_vld (word_vld)
  );

  assign lock_n = ~locked;

endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned MISS_W  = 4
) (
  input logic               clk,
  input logic               srst,
  input logic               frame_end,
  input logic               locked,
  input logic [FRAME_W-1:0] cand_mask,
  input logic [MISS_W-1:0]  miss_cnt,
  input logic               word_vld,
  input logic               lock_evt,
  input logic               restart_evt,
  input logic               drop_evt
);

  localparam logic [FRAME_W-1:0] ALL_CAND = {FRAME_W{1'b1}};

  // R3
  reset_state_chk: assert property (@(posedge clk)
    srst |=> (!locked && !word_vld && cand_mask == ALL_CAND));

  // R5
  single_cand_chk: assert property (@(posedge clk) disable iff (srst)
    locked |-> ($countones(cand_mask) == 1));

  // R5
  lock_at_window_chk: assert property (@(posedge clk) disable iff (srst)
    $rose(locked) |-> $past(frame_end));

  // R5
  lock_evt_chk: assert property (@(posedge clk) disable iff (srst)
    lock_evt |=> locked);

  // R7
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (srst)
    cand_mask != '0);

  // R7
  restart_refill_chk: assert property (@(posedge clk) disable iff (srst)
    restart_evt |=> (cand_mask == ALL_CAND && !locked));

  // R8
  drop_cause_chk: assert property (@(posedge clk) disable iff (srst)
    $fell(locked) |-> ($past(drop_evt) || $past(srst)));

  // R8
  miss_idle_chk: assert property (@(posedge clk) disable iff (srst)
    !locked |-> (miss_cnt == '0));

  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (srst)
    word_vld |=> !word_vld);

  // R10
  strobe_locked_chk: assert property (@(posedge clk) disable iff (srst)
    word_vld |-> $past(locked));

endmodule

bind frame_aligner fa_checker #(.FRAME_W(FRAME_W), .MISS_W(MISS_W)) i_fa_checker (
  .clk         (clk),
  .srst        (srst),
  .frame_end   (frame_end),
  .locked      (locked),
  .cand_mask   (cand_mask),
  .miss_cnt    (miss_cnt),
  .word_vld    (word_vld),
  .lock_evt    (lock_evt),
  .restart_evt (restart_evt),
  .drop_evt    (drop_evt)
);

// File: tb/test_frame_aligner.sv
module test_frame_aligner;
  localparam int DW = 10;
  localparam int MW = 4;
  localparam logic [DW-1:0] SYNC_DATA = 10'b11111_00000;
  localparam logic [DW-1:0] AMBIG_DATA = 10'b00000_11111;

  logic          clk = 1'b0;
  logic          srst = 1'b1;
  logic          ser_bit = 1'b0;
  logic [MW-1:0] miss_lim = 4'd3;
  logic          lock_n;
  logic [DW-1:0] word_out;
  logic          word_vld;

  always #2 clk = ~clk;

  frame_aligner #(.DATA_W(DW), .MISS_W(MW)) i_frame_aligner (
    .clk(clk), .srst(srst), .ser_bit(ser_bit), .miss_lim(miss_lim),
    .lock_n(lock_n), .word_out(word_out), .word_vld(word_vld)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;
  logic prev_vld = 1'b0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk);
    ser_bit = b;
  endtask

  // Driver: sends one frame and queues its word if it will be issued.
  task automatic send_frame(input logic st, input logic [DW-1:0] d, input logic sp);
    put_bit(st);
    for (int i = DW - 1; i >= 0; i--) put_bit(d[i]);
    @(negedge clk);
    ser_bit = sp;
    if (lock_n == 1'b0) exp_q.push_back(d);
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic next_rand(output logic [DW-1:0] d);
    for (int i = 0; i < DW; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d[i] = lfsr[0];
    end
  endtask

  task automatic rand_frames(input int n);
    logic [DW-1:0] d;
    for (int k = 0; k < n; k++) begin
      next_rand(d);
      send_frame(1'b1, d, 1'b0);
    end
  endtask

  task automatic lock_on_rand(input string req, input int limit);
    logic [DW-1:0] d;
    int nf;
    nf = 0;
    while (lock_n && nf < limit) begin
      next_rand(d);
      send_frame(1'b1, d, 1'b0);
      settle();
      nf++;
    end
    check(lock_n == 1'b0, req, "lock on framed random data (lock_n)", lock_n, 0);
  endtask

  // Bit after release is window slot 0 and is driven low.
  task automatic reset_dut();
    @(negedge clk);
    ser_bit = 1'b0;
    @(negedge clk);
    srst = 1'b1;
    repeat (3) @(negedge clk);
    srst = 1'b0;
    ser_bit = 1'b0;
  endtask

  // Monitor: pops the scoreboard on every strobe.
  always @(negedge clk) begin
    if (!srst && word_vld) begin
      check(!prev_vld, "R2", "strobe longer than one cycle", 1, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "strobe with no expected word", int'(word_out), -1);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(word_out == e, "R1", "deframed word", int'(word_out), int'(e));
      end
    end
    prev_vld <= word_vld;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int nf;
    bit saw_lock;
    reset_dut();
    #1;
    // R3: state right after reset
    check(lock_n == 1'b1, "R3", "lock_n after reset", lock_n, 1);
    check(word_vld == 1'b0, "R3", "word_vld after reset", word_vld, 0);
    check(word_out == '0, "R3", "word_out after reset", int'(word_out), 0);

    // R4: sync frames lock quickly
    nf = 0;
    while (lock_n && nf < 60) begin
      send_frame(1'b1, SYNC_DATA, 1'b0);
      settle();
      nf++;
    end
    check(!lock_n && nf <= 42, "R4", "frames to lock on sync", nf, 42);
    for (int k = 0; k < 4; k++) send_frame(1'b1, SYNC_DATA, 1'b0);
    rand_frames(20);   // R1 words checked by the monitor

    // R8: misses below the limit keep lock; a good frame clears the count
    miss_lim = 4'd3;
    send_frame(1'b1, 10'h2A5, 1'b0);
    send_frame(1'b0, '0, 1'b0);
    send_frame(1'b0, '0, 1'b0);
    settle();
    check(lock_n == 1'b0, "R8", "lock after two misses", lock_n, 0);
    send_frame(1'b1, 10'h13C, 1'b0);
    send_frame(1'b0, '0, 1'b0);
    send_frame(1'b0, '0, 1'b0);
    settle();
    check(lock_n == 1'b0, "R8", "count cleared by good frame", lock_n, 0);
    send_frame(1'b0, '0, 1'b0);
    settle();
    check(lock_n == 1'b1, "R8", "lock dropped at third miss", lock_n, 1);
    lock_on_rand("R8", 60);
    rand_frames(6);

    // R9: a zero limit drops on the first miss
    miss_lim = 4'd0;
    send_frame(1'b1, 10'h0F1, 1'b0);
    settle();
    check(lock_n == 1'b0, "R9", "still locked before miss", lock_n, 0);
    send_frame(1'b0, '0, 1'b0);
    settle();
    check(lock_n == 1'b1, "R9", "zero limit drops on one miss", lock_n, 1);
    miss_lim = 4'd3;
    lock_on_rand("R9", 60);
    rand_frames(4);

    // R11: synchronous reset while locked
    check(lock_n == 1'b0, "R11", "locked before reset", lock_n, 0);
    reset_dut();
    #1;
    check(lock_n == 1'b1, "R11", "lock abandoned by reset", lock_n, 1);
    check(word_vld == 1'b0, "R11", "no strobe after reset", word_vld, 0);
    check(word_out == '0, "R11", "word cleared by reset", int'(word_out), 0);

    // R5: lock on framed pseudorandom data from a cold start
    lock_on_rand("R5", 60);
    rand_frames(20);

    // R6: permanent second edge prevents lock
    reset_dut();
    saw_lock = 1'b0;
    for (int k = 0; k < 40; k++) begin
      send_frame(1'b1, AMBIG_DATA, 1'b0);
      settle();
      if (!lock_n) saw_lock = 1'b1;
    end
    check(!saw_lock, "R6", "lock with two survivors", saw_lock, 0);
    check(lock_n == 1'b1, "R6", "lock_n with ambiguous edges", lock_n, 1);

    // R7: two-bit slip on a window boundary empties the mask
    put_bit(1'b0);
    put_bit(1'b0);
    nf = 0;
    while (lock_n && nf < 10) begin
      send_frame(1'b1, SYNC_DATA, 1'b0);
      settle();
      nf++;
    end
    check(!lock_n && nf <= 3, "R7", "frames to relock after empty mask", nf, 2);
    rand_frames(8);

    repeat (3) @(negedge clk);
    // R2: every queued word was issued
    check(exp_q.size() == 0, "R2", "words left unissued", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule